// File: doc/BRIEF.md
# Keyed Record Reordering Unit

This unit takes fixed-length records that arrive out of sequence on a 16-bit input stream and delivers them in sequence on a 32-bit output stream. The first 16-bit word of every record is a sequence key. The unit uses the key to choose where the record is stored. It then drops the key and sends out the remaining payload words, two per output word, when that record is the next one due.

The record length, in 16-bit words with the key included, is a parameter. So is the number of key bits that pick a storage slot. Sequence numbers count modulo the slot count. Each slot has a filled flag. An output pointer starts at slot 0 and moves to the next slot only after a complete record has been sent from the current one. The upstream side is held off when the slot its key selects is still occupied.

Top module: `rru_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and the first record released is the one whose key has low KEY_BITS bits equal to 0.
- R2: Records leave strictly in key order, modulo 2^KEY_BITS. After the last output word of the record in slot s is accepted, the next record released is from slot (s+1) mod 2^KEY_BITS, with wrap from the top slot to slot 0.
- R3: `out_valid` stays 0 while the record due next has not been completely received, even if later records are already stored.
- R4: While a key word is presented whose slot (key bits [KEY_BITS-1:0]) holds an unreleased record, `in_ready` is 0 and the word is not taken. `in_ready` returns to 1 after that slot's record has been fully released.
- R5: The key word is not part of the output. Payload words p0, p1, ... are packed into output words with the earlier word in bits [31:16] and the later word in bits [15:0].
- R6: When the payload word count (REC_WORDS-1) is odd, bits [15:0] of the final output word of a record are 0.
- R7: `out_last` is 1 on the final output word of each record and 0 on every other output word. A record produces ceil((REC_WORDS-1)/2) output words.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_last` and `out_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle if in_valid |
| in_data | input | 16 | Key word, then payload words |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 32 | Packed payload pair |
| out_last | output | 1 | Final output word of the record |

## Verification
The records are fed in several orders. Reversed order shows that release waits for the key that is due and ignores how records arrive. In-order arrival shows that a filled head slot is released at once. A full eight-slot sweep with keys above the slot count checks the modulo wrap of the pointer. A key that collides with a held slot shows the stall on the input and its release. Holding the output back shows that the data stays stable. Every payload word is derived from its key and position, so a word that is misplaced, swapped or left unpadded shows up in the output.

// File: rtl/rru_pkg.sv
package rru_pkg;
    localparam int DEF_KEY_BITS  = 3;
    localparam int DEF_REC_WORDS = 4;

    function automatic int half_up(input int n);
        return (n + 1) / 2;
    endfunction
endpackage

// File: rtl/rru_store.sv
module rru_store #(
    parameter int SLOTS = 8,
    parameter int PAY   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(SLOTS)-1:0] wr_slot,
    input  logic [$clog2(PAY+1)-1:0] wr_idx,
    input  logic [15:0]              wr_data,
    input  logic                     set_en,
    input  logic [$clog2(SLOTS)-1:0] set_slot,
    input  logic                     clr_en,
    input  logic [$clog2(SLOTS)-1:0] clr_slot,
    input  logic [$clog2(SLOTS)-1:0] rd_slot,
    output logic [PAY-1:0][15:0]     rd_words,
    output logic [SLOTS-1:0]         filled
);
    typedef struct packed {
        logic [SLOTS-1:0][PAY-1:0][15:0] mem;
        logic [SLOTS-1:0]                flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en)  st_d.mem[wr_slot][wr_idx] = wr_data;
        if (set_en) st_d.flag[set_slot] = 1'b1;
        if (clr_en) st_d.flag[clr_slot] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= '0;
            st_q.mem  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_words = st_q.mem[rd_slot];
    assign filled   = st_q.flag;

    // R4
    free_slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !st_q.flag[set_slot]);

    // R2
    clear_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> st_q.flag[clr_slot]);
endmodule

// File: rtl/rru_writer.sv
module rru_writer #(
    parameter int SLOTS     = 8,
    parameter int REC_WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [15:0]              in_data,
    input  logic [SLOTS-1:0]         filled,
    output logic                     wr_en,
    output logic [$clog2(SLOTS)-1:0] wr_slot,
    output logic [$clog2(REC_WORDS)-1:0] wr_idx,
    output logic                     set_en
);
    localparam int SW = $clog2(SLOTS);
    localparam int CW = $clog2(REC_WORDS);
    localparam logic [CW-1:0] LAST_CNT = CW'(REC_WORDS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [SW-1:0] slot;
    } st_t;

    st_t st_d, st_q;
    logic at_key, take;

    always_comb begin
        st_d   = st_q;
        at_key = (st_q.cnt == '0);
        in_ready = at_key ? !filled[in_data[SW-1:0]] : 1'b1;
        take   = in_valid && in_ready;
        if (take) begin
            if (at_key) st_d.slot = in_data[SW-1:0];
            st_d.cnt = (st_q.cnt == LAST_CNT) ? '0 : st_q.cnt + 1'b1;
        end
        wr_en   = take && !at_key;
        wr_slot = st_q.slot;
        wr_idx  = st_q.cnt - 1'b1;
        set_en  = take && (st_q.cnt == LAST_CNT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> (st_q.cnt == '0));
endmodule

// File: rtl/rru_reader.sv
module rru_reader #(
    parameter int SLOTS = 8,
    parameter int PAY   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLOTS-1:0]         filled,
    input  logic [PAY-1:0][15:0]     rd_words,
    output logic [$clog2(SLOTS)-1:0] rd_slot,
    output logic                     clr_en,
    output logic [$clog2(SLOTS)-1:0] clr_slot,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [31:0]              out_data,
    output logic                     out_last
);
    localparam int SW    = $clog2(SLOTS);
    localparam int BEATS = rru_pkg::half_up(PAY);
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    typedef struct packed {
        logic [SW-1:0] ptr;
        logic [BW-1:0] beat;
    } st_t;

    st_t st_d, st_q;
    logic fire;

    always_comb begin
        st_d      = st_q;
        rd_slot   = st_q.ptr;
        out_valid = filled[st_q.ptr];
        out_last  = (st_q.beat == LAST_BEAT);
        out_data  = '0;
        for (int i = 0; i < PAY; i++) begin
            if (i == 2 * int'(st_q.beat))     out_data[31:16] = rd_words[i];
            if (i == 2 * int'(st_q.beat) + 1) out_data[15:0]  = rd_words[i];
        end
        fire     = out_valid && out_ready;
        clr_en   = fire && out_last;
        clr_slot = st_q.ptr;
        if (fire) begin
            if (out_last) begin
                st_d.beat = '0;
                st_d.ptr  = st_q.ptr + 1'b1;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (st_q.ptr == SW'($past(st_q.ptr) + 1'b1)));

    generate
        if (PAY % 2 == 1) begin : g_pad
            // R6
            pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_last) |-> (out_data[15:0] == 16'h0));
        end
    endgenerate
endmodule

// File: rtl/rru_top.sv
module rru_top #(
    parameter int KEY_BITS  = rru_pkg::DEF_KEY_BITS,
    parameter int REC_WORDS = rru_pkg::DEF_REC_WORDS
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_last
);
    localparam int SLOTS = 1 << KEY_BITS;
    localparam int PAY   = REC_WORDS - 1;

    logic [SLOTS-1:0]          filled;
    logic [PAY-1:0][15:0]      rd_words;
    logic                      wr_en, set_en, clr_en;
    logic [KEY_BITS-1:0]       wr_slot, rd_slot, clr_slot;
    logic [$clog2(REC_WORDS)-1:0] wr_idx;

    rru_writer #(.SLOTS(SLOTS), .REC_WORDS(REC_WORDS)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .filled(filled), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_idx(wr_idx), .set_en(set_en)
    );

    rru_store #(.SLOTS(SLOTS), .PAY(PAY)) u_st (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_idx(wr_idx), .wr_data(in_data), .set_en(set_en), .set_slot(wr_slot),
        .clr_en(clr_en), .clr_slot(clr_slot), .rd_slot(rd_slot),
        .rd_words(rd_words), .filled(filled)
    );

    rru_reader #(.SLOTS(SLOTS), .PAY(PAY)) u_rd (
        .clk(clk), .rst_n(rst_n), .filled(filled), .rd_words(rd_words),
        .rd_slot(rd_slot), .clr_en(clr_en), .clr_slot(clr_slot),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );
endmodule

// File: tb/rru_top_test.sv
module rru_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_ready = 1'b0;
    logic        in_ready, out_valid, out_last;
    logic [31:0] out_data;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rru_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    function automatic logic [15:0] pw(input int key, input int j);
        return 16'hA000 | 16'((key & 8'hFF) << 4) | 16'(j);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_payload(input int key);
        for (int j = 0; j < 3; j++) push(pw(key, j));
    endtask

    task automatic send_rec(input int key);
        push(16'(key));
        send_payload(key);
    endtask

    // pop a record, payload 3 words -> 2 beats, second padded (R5, R6, R7)
    task automatic pop_rec(input int key, input string req);
        for (int b = 0; b < 2; b++) begin
            @(negedge clk);
            out_ready = 1'b1;
            #1;
            while (!out_valid) begin
                @(negedge clk);
                #1;
            end
            if (b == 0) check({req, " R5 beat0"}, out_data, {pw(key, 0), pw(key, 1)});
            else        check({req, " R6 beat1"}, out_data, {pw(key, 2), 16'h0000});
            check("R7 last flag", out_last, (b == 1));
            @(posedge clk);
            #1;
            out_ready = 1'b0;
        end
    endtask

    task automatic t_reset;
        #1;
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 in_ready after reset", in_ready, 1);
    endtask

    task automatic t_reverse;
        send_rec(2);
        send_rec(1);
        @(negedge clk); #1;
        check("R3 wait for key 0", out_valid, 0);
        send_rec(0);
        pop_rec(0, "R1 first key0");
        pop_rec(1, "R2 order key1");
        pop_rec(2, "R2 order key2");
        @(negedge clk); #1;
        check("R3 empty after drain", out_valid, 0);
    endtask

    task automatic t_inorder;
        send_rec(3);
        @(negedge clk); #1;
        check("R2 head ready", out_valid, 1);
        pop_rec(3, "R2 in-order key3");
    endtask

    task automatic t_wrap_stall;
        for (int k = 11; k >= 4; k--) send_rec(k);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'd12;
        #1;
        check("R4 stall on held slot", in_ready, 0);
        @(negedge clk); #1;
        check("R4 stall persists", in_ready, 0);
        in_valid = 1'b0;
        pop_rec(4, "R2 wrap key4");
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'd12;
        #1;
        check("R4 ready after release", in_ready, 1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        send_payload(12);
        for (int k = 5; k <= 12; k++) pop_rec(k, "R2 wrap order");
    endtask

    task automatic t_backpressure;
        logic [31:0] snap;
        send_rec(13);
        @(negedge clk); #1;
        snap = out_data;
        repeat (3) @(negedge clk);
        #1;
        check("R8 valid held", out_valid, 1);
        check("R8 data held", out_data, snap);
        check("R8 last held", out_last, 0);
        pop_rec(13, "R8 after hold");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_reverse;
        t_inorder;
        t_wrap_stall;
        t_backpressure;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule